// File: doc/BRIEF.md
# Byte-Wise EPROM Programming Sequencer

This block is a clocked controller that burns an image into an external byte-wide EPROM and then proves the result. The image arrives one byte at a time over a valid/ready stream, in ascending address order. For every address the sequencer runs a loop: it drives the byte, applies one fixed-width program strobe, releases the data bus and reads the cell back. When the read-back matches, it moves on at once and applies no extra margin pulse. When the read-back does not match, it repeats the loop, up to a cap on attempts per address.

When the last address has been programmed, the block makes two full read-only check passes over the array. The first pass runs with a raised supply request and the second with a lowered one. The stream supplies the image again for each check pass, so the block holds only one byte of data. The voltages are produced elsewhere. This block only raises digital requests: a high-voltage enable and a two-bit supply-level code. The run ends in a sticky done state, or in a sticky fail state that reports the failing address. A new start pulse launches a new run.

All microsecond intervals come from one cycle counter. Its limits are derived from a cycles-per-microsecond parameter.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset, and while idle, the outputs are: rom_ce_n=1, rom_oe_n=1, rom_pgm_n=1, rom_dout_en=0, vpp_req=0, vcc_sel=0, in_ready=0, done=0, fail=0, rom_addr=0 and fail_addr=0.
- R2: Each program strobe holds rom_pgm_n low for exactly PULSE_US*CYC_PER_US cycles.
- R3: For SETUP_US*CYC_PER_US cycles before the strobe falls, the address is held, the byte is driven (rom_dout_en=1), rom_ce_n is low, vpp_req is 1 and vcc_sel is 1. The byte stays driven for the same number of cycles after the strobe rises.
- R4: The data drive is released for SETUP_US*CYC_PER_US cycles before rom_oe_n falls. rom_oe_n is then low for READ_CYC cycles, with the strobe high. The drive is never on while rom_oe_n is low. After rom_oe_n rises, a release interval of SETUP_US*CYC_PER_US cycles with no drive follows.
- R5: A read-back mismatch in the programming pass leads to another strobe on the same address. The attempt count restarts at each new address. A mismatch on attempt MAX_TRIES sets fail, with fail_addr equal to that address, and no further strobe is given.
- R6: A matching read-back ends the work on that address. No further strobe is applied to it, and the next byte is fetched.
- R7: in_ready is 1 only while the block waits for a byte, and a byte is taken on a cycle with in_valid=1 and in_ready=1. Bytes are consumed for addresses 0 to 2^ADDR_W-1 in order, once in the programming pass and once in each check pass.
- R8: The first check pass runs with vcc_sel=2 and the second with vcc_sel=3. Both passes read each address without any strobe. A mismatch sets fail with fail_addr equal to that address.
- R9: done is set after the last address of the second check pass. Both done and fail are sticky, with idle pin levels, and are never 1 together. In the done, fail or idle state, a start pulse clears them and begins again at address 0.
- R10: During the programming pass, vcc_sel=1 and vpp_req=1, and a strobe occurs only in this setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run from idle, done or fail |
| in_valid | input | 1 | Image byte is valid |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Block takes an image byte |
| rom_addr | output | ADDR_W | EPROM address |
| rom_dout | output | 8 | Byte driven to the EPROM data pins |
| rom_dout_en | output | 1 | Data pin drive enable |
| rom_din | input | 8 | Byte read from the EPROM |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_pgm_n | output | 1 | Program strobe, active low |
| vpp_req | output | 1 | Requests the programming voltage |
| vcc_sel | output | 2 | Supply level code: 0 read, 1 program, 2 check high, 3 check low |
| done | output | 1 | Run finished with all bytes good |
| fail | output | 1 | Run aborted |
| fail_addr | output | ADDR_W | Failing address while fail is 1, else 0 |

## Verification
Some verdicts land in the same cycle as another event. At the last address of a pass, the read-back verdict coincides with the pass switch, where the address wraps to 0 and the supply code steps. On the final attempt, a mismatch coincides with the attempt cap. The bench sets up both cases with a scripted EPROM model. In that model each address needs a chosen number of strobes, and one cell can be made to read wrong only at the low supply code. The reference model then checks every cycle that the next fetch shows the new supply code at address 0, or that fail comes up with the right address and no extra strobe is given.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP,
        ST_READ,
        ST_RELEASE,
        ST_DONE,
        ST_FAIL
    } step_t;

    // The encoding is visible on vcc_sel, so the values are fixed.
    typedef enum logic [1:0] {
        SUP_READ   = 2'd0,
        SUP_PROG   = 2'd1,
        SUP_CHK_HI = 2'd2,
        SUP_CHK_LO = 2'd3
    } supply_t;

endpackage

// File: rtl/eprom_burn_timer.sv
module eprom_burn_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = restart ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // The count restarts on entry to a state, so the state lasts `limit` cycles.
    assign expired = (cnt_q == limit - 1'b1);

endmodule

// File: rtl/eprom_burn_fsm.sv
module eprom_burn_fsm
    import eprom_burn_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int CW        = 13,
    parameter int TRY_W     = 5,
    parameter int MAX_TRIES = 25,
    parameter int PULSE_CYC = 5000,
    parameter int SETUP_CYC = 100,
    parameter int READ_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [7:0]        rom_din,
    input  logic              expired,
    output logic              restart,
    output logic [CW-1:0]     limit,
    output logic              in_ready,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [7:0]        rom_dout,
    output logic              rom_dout_en,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_pgm_n,
    output logic              vpp_req,
    output logic [1:0]        vcc_sel,
    output logic              done,
    output logic              fail
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(MAX_TRIES - 1);

    typedef struct packed {
        step_t             st;
        supply_t           ph;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        img;
        logic [TRY_W-1:0]  tries;
        logic              again;
        logic              done;
        logic              fail;
    } ctx_t;

    localparam ctx_t CTX_RST = '{st: ST_IDLE, ph: SUP_PROG, addr: '0, img: '0,
                                 tries: '0, again: 1'b0, done: 1'b0, fail: 1'b0};

    ctx_t d, q;
    logic active;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    d.st   = ST_FETCH;
                    d.ph   = SUP_PROG;
                    d.addr = '0;
                    d.done = 1'b0;
                    d.fail = 1'b0;
                end
            end
            ST_FETCH: begin
                if (in_valid) begin
                    d.img   = in_data;
                    d.tries = '0;
                    d.st    = (q.ph == SUP_PROG) ? ST_SETUP : ST_GAP;
                end
            end
            ST_SETUP:   if (expired) d.st = ST_PULSE;
            ST_PULSE:   if (expired) d.st = ST_HOLD;
            ST_HOLD:    if (expired) d.st = ST_GAP;
            ST_GAP:     if (expired) d.st = ST_READ;
            ST_READ: begin
                if (expired) begin
                    if (rom_din == q.img) begin
                        d.again = 1'b0;
                        d.st    = ST_RELEASE;
                    end else if (q.ph != SUP_PROG || q.tries == LAST_TRY) begin
                        d.fail = 1'b1;
                        d.st   = ST_FAIL;
                    end else begin
                        d.tries = q.tries + 1'b1;
                        d.again = 1'b1;
                        d.st    = ST_RELEASE;
                    end
                end
            end
            ST_RELEASE: begin
                if (expired) begin
                    if (q.again) begin
                        d.st = ST_SETUP;
                    end else if (q.addr != LAST_ADDR) begin
                        d.addr = q.addr + 1'b1;
                        d.st   = ST_FETCH;
                    end else if (q.ph == SUP_CHK_LO) begin
                        d.done = 1'b1;
                        d.st   = ST_DONE;
                    end else begin
                        d.ph   = (q.ph == SUP_PROG) ? SUP_CHK_HI : SUP_CHK_LO;
                        d.addr = '0;
                        d.st   = ST_FETCH;
                    end
                end
            end
            default: d = CTX_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTX_RST;
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            ST_PULSE: limit = CW'(PULSE_CYC);
            ST_READ:  limit = CW'(READ_CYC);
            default:  limit = CW'(SETUP_CYC);
        endcase
    end

    assign restart     = (d.st != q.st);
    assign active      = !(q.st inside {ST_IDLE, ST_DONE, ST_FAIL});
    assign in_ready    = (q.st == ST_FETCH);
    assign rom_addr    = q.addr;
    assign rom_dout    = q.img;
    assign rom_dout_en = (q.st inside {ST_SETUP, ST_PULSE, ST_HOLD});
    assign rom_ce_n    = !active;
    assign rom_oe_n    = (q.st != ST_READ);
    assign rom_pgm_n   = (q.st != ST_PULSE);
    assign vpp_req     = active;
    assign vcc_sel     = active ? q.ph : SUP_READ;
    assign done        = q.done;
    assign fail        = q.fail;

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq #(
    parameter int ADDR_W     = 18,
    parameter int CYC_PER_US = 50,
    parameter int PULSE_US   = 100,
    parameter int SETUP_US   = 2,
    parameter int READ_CYC   = 8,
    parameter int MAX_TRIES  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [7:0]        rom_dout,
    output logic              rom_dout_en,
    input  logic [7:0]        rom_din,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_pgm_n,
    output logic              vpp_req,
    output logic [1:0]        vcc_sel,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int PULSE_CYC = PULSE_US * CYC_PER_US;
    localparam int SETUP_CYC = SETUP_US * CYC_PER_US;
    localparam int CW        = $clog2(PULSE_CYC + 1);
    localparam int TRY_W     = $clog2(MAX_TRIES + 1);

    logic          restart;
    logic          expired;
    logic [CW-1:0] limit;

    eprom_burn_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    eprom_burn_fsm #(
        .ADDR_W    (ADDR_W),
        .CW        (CW),
        .TRY_W     (TRY_W),
        .MAX_TRIES (MAX_TRIES),
        .PULSE_CYC (PULSE_CYC),
        .SETUP_CYC (SETUP_CYC),
        .READ_CYC  (READ_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .rom_din     (rom_din),
        .expired     (expired),
        .restart     (restart),
        .limit       (limit),
        .in_ready    (in_ready),
        .rom_addr    (rom_addr),
        .rom_dout    (rom_dout),
        .rom_dout_en (rom_dout_en),
        .rom_ce_n    (rom_ce_n),
        .rom_oe_n    (rom_oe_n),
        .rom_pgm_n   (rom_pgm_n),
        .vpp_req     (vpp_req),
        .vcc_sel     (vcc_sel),
        .done        (done),
        .fail        (fail)
    );

    assign fail_addr = fail ? rom_addr : '0;

endmodule

// File: rtl/eprom_burn_chk.sv
module eprom_burn_chk #(
    parameter int ADDR_W    = 18,
    parameter int PULSE_CYC = 5000,
    parameter int SETUP_CYC = 100,
    parameter int MAX_TRIES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ready,
    input  logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_dout_en,
    input  logic              rom_ce_n,
    input  logic              rom_oe_n,
    input  logic              rom_pgm_n,
    input  logic              vpp_req,
    input  logic [1:0]        vcc_sel,
    input  logic              done,
    input  logic              fail
);
    localparam int LW = $clog2(PULSE_CYC + 2);
    localparam int PW = $clog2(MAX_TRIES + 2);

    logic [LW-1:0]     low_cnt, setup_cnt, gap_cnt;
    logic [PW-1:0]     strobe_cnt;
    logic [ADDR_W-1:0] addr_prev;
    logic              pgm_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            setup_cnt  <= '0;
            gap_cnt    <= '0;
            strobe_cnt <= '0;
            addr_prev  <= '0;
            pgm_prev   <= 1'b1;
        end else begin
            addr_prev <= rom_addr;
            pgm_prev  <= rom_pgm_n;
            low_cnt   <= rom_pgm_n ? '0 : low_cnt + 1'b1;
            if (rom_pgm_n && rom_dout_en && !rom_ce_n && vpp_req && vcc_sel == 2'd1
                && rom_addr == addr_prev)
                setup_cnt <= (setup_cnt < LW'(SETUP_CYC)) ? setup_cnt + 1'b1 : setup_cnt;
            else
                setup_cnt <= '0;
            if (rom_dout_en)
                gap_cnt <= '0;
            else if (rom_oe_n && gap_cnt < LW'(SETUP_CYC))
                gap_cnt <= gap_cnt + 1'b1;
            if (in_valid && in_ready)
                strobe_cnt <= '0;
            else if (pgm_prev && !rom_pgm_n && strobe_cnt < PW'(MAX_TRIES + 1))
                strobe_cnt <= strobe_cnt + 1'b1;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_pgm_n) |-> low_cnt == LW'(PULSE_CYC)); // R2
    AST_PULSE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_pgm_n) |-> setup_cnt >= LW'(SETUP_CYC)); // R3
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rom_dout_en |-> rom_oe_n); // R4
    AST_VERIFY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_oe_n) |-> gap_cnt >= LW'(SETUP_CYC)); // R4
    AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_cnt <= PW'(MAX_TRIES)); // R5
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!rom_ce_n && rom_oe_n && rom_pgm_n && !rom_dout_en)); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R9
    AST_STROBE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_pgm_n |-> (vcc_sel == 2'd1 && vpp_req && !rom_ce_n)); // R10

endmodule

bind eprom_burn_seq eprom_burn_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC),
    .SETUP_CYC (SETUP_CYC),
    .MAX_TRIES (MAX_TRIES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .rom_addr    (rom_addr),
    .rom_dout_en (rom_dout_en),
    .rom_ce_n    (rom_ce_n),
    .rom_oe_n    (rom_oe_n),
    .rom_pgm_n   (rom_pgm_n),
    .vpp_req     (vpp_req),
    .vcc_sel     (vcc_sel),
    .done        (done),
    .fail        (fail)
);

// File: tb/eprom_burn_seq_tb_top.sv
module eprom_burn_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 2;
    localparam int NA  = 4;
    localparam int CPU = 2;
    localparam int PUS = 100;
    localparam int SUS = 2;
    localparam int RC  = 2;
    localparam int MT  = 25;
    localparam int S   = SUS * CPU;
    localparam int P   = PUS * CPU;

    logic          clk = 1'b0;
    logic          rst_n, start, in_valid, in_ready;
    logic [7:0]    in_data, rom_dout, rom_din;
    logic [AW-1:0] rom_addr, fail_addr;
    logic          rom_dout_en, rom_ce_n, rom_oe_n, rom_pgm_n, vpp_req, done, fail;
    logic [1:0]    vcc_sel;

    int   nchk = 0, nerr = 0;
    bit   finished = 0;
    logic [7:0] img [NA];
    int   need [NA];
    logic [7:0] mem [NA];
    int   pulses [NA];
    bit   weak_on = 0;
    int   weak_a = 0;
    int   idx = 0;
    int   stall = 0;
    logic [7:0] flip;

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_burn_seq #(.ADDR_W(AW), .CYC_PER_US(CPU), .PULSE_US(PUS), .SETUP_US(SUS),
                     .READ_CYC(RC), .MAX_TRIES(MT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rom_addr(rom_addr), .rom_dout(rom_dout),
        .rom_dout_en(rom_dout_en), .rom_din(rom_din), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_pgm_n(rom_pgm_n), .vpp_req(vpp_req),
        .vcc_sel(vcc_sel), .done(done), .fail(fail), .fail_addr(fail_addr));

    // EPROM model: a cell takes the driven zeros once it has had need[] strobes.
    always @(posedge rom_pgm_n) begin
        if (rom_ce_n === 1'b0 && vpp_req === 1'b1) begin
            pulses[rom_addr] = pulses[rom_addr] + 1;
            if (pulses[rom_addr] >= need[rom_addr])
                mem[rom_addr] = mem[rom_addr] & rom_dout;
        end
    end
    assign flip    = (weak_on && vcc_sel == 2'd3 && int'(rom_addr) == weak_a) ? 8'h01 : 8'h00;
    assign rom_din = (!rom_ce_n && !rom_oe_n) ? (mem[rom_addr] ^ flip) : 8'hFF;

    // Stream source, updated just after each rising edge.
    initial begin
        bit hs;
        in_valid = 1'b0;
        in_data  = 8'h00;
        forever begin
            @(posedge clk);
            hs = in_valid && in_ready;
            #1;
            if (hs) idx = (idx + 1) % NA;
            if (stall > 0) begin
                in_valid = 1'b0;
                stall = stall - 1;
            end else begin
                in_valid = rst_n;
            end
            in_data = img[idx];
        end
    end

    function automatic logic [9:0] pins(bit ce, bit oe, bit pg, bit dr, bit rd,
                                         bit [1:0] vs, bit vp, bit dn, bit fl);
        return {ce, oe, pg, dr, rd, vs, vp, dn, fl};
    endfunction

    task automatic see(input int n, input string tag, input logic [9:0] ep,
                       input int a, input logic [7:0] d, input int fa);
        repeat (n) begin
            logic [9:0] gp;
            bit ok;
            gp = {rom_ce_n, rom_oe_n, rom_pgm_n, rom_dout_en, in_ready,
                  vcc_sel, vpp_req, done, fail};
            ok = (gp === ep) && (rom_addr === AW'(a)) && (fail_addr === AW'(fa))
                 && (!ep[6] || rom_dout === d);
            nchk++;
            if (!ok) begin
                nerr++;
                $display("FAIL %s t=%0t pins got %b exp %b addr got %0d exp %0d data got %h exp %h faddr got %0d exp %0d",
                         tag, $time, gp, ep, rom_addr, a, rom_dout, d, fail_addr, fa);
            end
            @(negedge clk);
        end
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    // Reference sequence for a whole run, derived from the requirements.
    task automatic expect_run();
        for (int p = 1; p <= 3; p++) begin
            for (int a = 0; a < NA; a++) begin
                bit v;
                if (p == 2 && a == 1) stall = 2 * S + RC + 3;
                do begin
                    v = in_valid;
                    see(1, "R7", pins(0,1,1,0,1,2'(p),1,0,0), a, 8'h00, 0);
                end while (!v);
                if (p == 1) begin
                    for (int t = 1; t <= MT; t++) begin
                        see(S,  "R3",  pins(0,1,1,1,0,2'd1,1,0,0), a, img[a], 0);
                        see(P,  "R2",  pins(0,1,0,1,0,2'd1,1,0,0), a, img[a], 0);
                        see(S,  "R3",  pins(0,1,1,1,0,2'd1,1,0,0), a, img[a], 0);
                        see(S,  "R4",  pins(0,1,1,0,0,2'd1,1,0,0), a, 8'h00, 0);
                        see(RC, "R4",  pins(0,0,1,0,0,2'd1,1,0,0), a, 8'h00, 0);
                        if (t >= need[a]) begin
                            see(S, "R6", pins(0,1,1,0,0,2'd1,1,0,0), a, 8'h00, 0);
                            break;
                        end else if (t == MT) begin
                            see(3, "R5", pins(1,1,1,0,0,2'd0,0,0,1), a, 8'h00, a);
                            return;
                        end else begin
                            see(S, "R5", pins(0,1,1,0,0,2'd1,1,0,0), a, 8'h00, 0);
                        end
                    end
                end else begin
                    see(S,  "R8", pins(0,1,1,0,0,2'(p),1,0,0), a, 8'h00, 0);
                    see(RC, "R8", pins(0,0,1,0,0,2'(p),1,0,0), a, 8'h00, 0);
                    if (weak_on && p == 3 && a == weak_a) begin
                        see(3, "R8", pins(1,1,1,0,0,2'd0,0,0,1), a, 8'h00, a);
                        return;
                    end
                    see(S, "R8", pins(0,1,1,0,0,2'(p),1,0,0), a, 8'h00, 0);
                end
            end
        end
        see(3, "R9", pins(1,1,1,0,0,2'd0,0,1,0), NA - 1, 8'h00, 0);
    endtask

    task automatic launch();
        for (int i = 0; i < NA; i++) begin
            mem[i] = 8'hFF;
            pulses[i] = 0;
        end
        idx = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        expect_run();
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        for (int i = 0; i < NA; i++) begin
            img[i] = 8'h00; need[i] = 1; mem[i] = 8'hFF; pulses[i] = 0;
        end
        repeat (2) @(negedge clk);
        see(2, "R1", pins(1,1,1,0,0,2'd0,0,0,0), 0, 8'h00, 0);
        rst_n = 1'b1;
        see(3, "R1", pins(1,1,1,0,0,2'd0,0,0,0), 0, 8'h00, 0);

        // Run A: retries on two addresses, stalls on the stream, clean finish.
        img[0] = 8'h3C; img[1] = 8'hA5; img[2] = 8'h00; img[3] = 8'h7E;
        need[0] = 1; need[1] = 3; need[2] = 2; need[3] = 1;
        weak_on = 0;
        stall = 3;
        launch();
        for (int i = 0; i < NA; i++) begin
            check_val("R6 strobes per address", pulses[i], need[i]);
            check_val("R6 stored byte", int'(mem[i]), int'(img[i]));
        end

        // Run B: address 1 never takes, so the cap is hit; restart from done.
        img[0] = 8'h12; img[1] = 8'h34; img[2] = 8'h56; img[3] = 8'h78;
        need[0] = 2; need[1] = 30; need[2] = 1; need[3] = 1;
        launch();
        check_val("R5 strobes at capped address", pulses[1], MT);
        check_val("R5 no strobe past fail", pulses[2], 0);

        // Run C: a cell that reads wrong only at the low check supply; restart from fail.
        img[0] = 8'hC3; img[1] = 8'h0F; img[2] = 8'hF0; img[3] = 8'h81;
        for (int i = 0; i < NA; i++) need[i] = 1;
        weak_on = 1;
        weak_a = 2;
        launch();
        for (int i = 0; i < NA; i++)
            check_val("R8 check passes give no strobe", pulses[i], 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL R9 watchdog expired before the run ended");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule